// File: doc/BRIEF.md
# Paired-Register Double-Precision Instruction Decoder

This block decodes one 32-bit instruction word into the control bundle that the rest of a pipeline needs to execute double-precision floating-point work on a register file of thirty-two 32-bit entries. Each 64-bit operand occupies two registers. The first register is named by a 5-bit field and holds the upper 32 bits. Its partner holds the lower 32 bits and sits at index r+1+p, where p is a per-operand stride bit carried in the instruction. The decoder is purely combinational. Its inputs are the instruction word and a feature-enable bit. It produces an operation select, the register indices of both halves of every operand, per-half read and write enables, and two controls that let six comparisons run on only three comparison primitives.

The six comparisons share hardware as follows. Equal and not-equal use the equality primitive, with the result inverted for not-equal. Greater-than and greater-or-equal reuse less-than and less-or-equal with the two operands exchanged. The fused multiply-add also reads the destination pair as an accumulator. Any encoding that cannot be executed raises the illegal flag and silences every enable. This covers a wrong major opcode, an unknown function code, a non-zero reserved field, a partner index past the last register, or a cleared feature-enable bit.

Top module: `fpd_pair_decoder`

## Requirements
- R1: Fields sit at major opcode [31:26] (must equal 6'b110010), d [25:21], a [20:16], b [15:11], dp bit 10, ap bit 9, bp bit 8, function [7:0]. Any other major opcode makes illegal_o 1.
- R2: When fp64_en_i is 0, every instruction is illegal.
- R3: With a legal instruction, op_o follows the function code: 0x10→1 (add), 0x11→2 (sub), 0x12→3 (mul), 0x13→4 (div), 0x16→5 (rem), 0x17→6 (madd), 0x14→7 (int to fp), 0x15→8 (fp to int), 0x34→9 (single to double), 0x35→10 (double to single), 0x18 and 0x19→11 (eq), 0x1A and 0x1C→12 (lt), 0x1B and 0x1D→13 (le).
- R4: Any function code outside the list in R3 is illegal.
- R5: For each of a, b and d, the *_hi_o output equals the field and the *_lo_o output equals (field+1+stride) mod 32, whatever the legality. The strides are ap, bp and dp.
- R6: An instruction is illegal if field+1+stride ≥ 32 for any pair operand it uses. Pairs it does not use are not checked.
- R7: cmp_swap_o is 1 for codes 0x1A and 0x1B only, and cmp_inv_o is 1 for 0x19 only. Both are 0 for every other or illegal instruction.
- R8: The comparisons (0x18–0x1D) need d = 0 and bit 10 = 0. They read pairs a and b and write nothing.
- R9: The conversions 0x14 and 0x15 need b = 0 and bit 8 = 0. They read pair a and write pair d.
- R10: Code 0x34 needs b = 0, bit 9 = 0 and bit 8 = 0. It reads only register a (src_a_re_o = 2'b10) and writes pair d.
- R11: Code 0x35 needs b = 0, bit 10 = 0 and bit 8 = 0. It reads pair a and writes only register d (dst_we_o = 2'b10).
- R12: Code 0x17 sets acc_re_o = 2'b11 so that pair d is also read. acc_re_o is 0 for every other instruction.
- R13: Enable bit 1 means the first register (hi) and bit 0 means the partner (lo). The arithmetic codes 0x10–0x13 and 0x16–0x17 read pairs a and b and write pair d. An illegal instruction drives op_o = 0 and every enable to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word |
| fp64_en_i | input | 1 | Paired double-precision support enabled |
| op_o | output | 4 | Operation select (0 = none) |
| src_a_hi_o | output | 5 | Operand a first register (upper word) |
| src_a_lo_o | output | 5 | Operand a partner register (lower word) |
| src_b_hi_o | output | 5 | Operand b first register |
| src_b_lo_o | output | 5 | Operand b partner register |
| dst_hi_o | output | 5 | Destination first register |
| dst_lo_o | output | 5 | Destination partner register |
| src_a_re_o | output | 2 | Read enables for operand a {hi, lo} |
| src_b_re_o | output | 2 | Read enables for operand b {hi, lo} |
| acc_re_o | output | 2 | Read enables for destination pair as accumulator |
| dst_we_o | output | 2 | Write enables for destination {hi, lo} |
| cmp_swap_o | output | 1 | Exchange comparison operands |
| cmp_inv_o | output | 1 | Invert comparison result |
| illegal_o | output | 1 | Instruction cannot be executed |

## Verification
The decoder holds no state, so a wrong class assignment or a bad partner-index carry shows at the ports in the same evaluation as the instruction that triggers it. It appears as a wrong op_o, a wrong enable pattern, or a missing illegal flag. The bench drives every function code against several field patterns, with the feature bit both set and clear. It sweeps each base index and stride up to the 32-register limit. Each result is compared against an arithmetic model, so an off-by-one in the pair bound shows on exactly the base-31 and base-30 vectors.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

  localparam int IDX_W   = 5;
  localparam int FUNC_W  = 8;
  localparam int MAJ_W   = 6;
  localparam int INSN_W  = 32;
  localparam int OP_W    = 4;
  localparam int NPAIR   = 3;
  localparam int OPND_A  = 0;
  localparam int OPND_B  = 1;
  localparam int OPND_D  = 2;

  localparam logic [MAJ_W-1:0] FPD_MAJOR = 6'b110010;

  localparam logic [FUNC_W-1:0] FN_ADD  = 8'h10;
  localparam logic [FUNC_W-1:0] FN_SUB  = 8'h11;
  localparam logic [FUNC_W-1:0] FN_MUL  = 8'h12;
  localparam logic [FUNC_W-1:0] FN_DIV  = 8'h13;
  localparam logic [FUNC_W-1:0] FN_I2F  = 8'h14;
  localparam logic [FUNC_W-1:0] FN_F2I  = 8'h15;
  localparam logic [FUNC_W-1:0] FN_REM  = 8'h16;
  localparam logic [FUNC_W-1:0] FN_FMA  = 8'h17;
  localparam logic [FUNC_W-1:0] FN_CEQ  = 8'h18;
  localparam logic [FUNC_W-1:0] FN_CNE  = 8'h19;
  localparam logic [FUNC_W-1:0] FN_CGT  = 8'h1A;
  localparam logic [FUNC_W-1:0] FN_CGE  = 8'h1B;
  localparam logic [FUNC_W-1:0] FN_CLT  = 8'h1C;
  localparam logic [FUNC_W-1:0] FN_CLE  = 8'h1D;
  localparam logic [FUNC_W-1:0] FN_S2D  = 8'h34;
  localparam logic [FUNC_W-1:0] FN_D2S  = 8'h35;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_MUL  = 4'd3,
    OP_DIV  = 4'd4,
    OP_REM  = 4'd5,
    OP_FMA  = 4'd6,
    OP_I2F  = 4'd7,
    OP_F2I  = 4'd8,
    OP_S2D  = 4'd9,
    OP_D2S  = 4'd10,
    OP_CEQ  = 4'd11,
    OP_CLT  = 4'd12,
    OP_CLE  = 4'd13
  } op_e;

  typedef enum logic [2:0] {
    CL_NONE  = 3'd0,
    CL_ARITH = 3'd1,
    CL_FMA   = 3'd2,
    CL_CONV  = 3'd3,
    CL_S2D   = 3'd4,
    CL_D2S   = 3'd5,
    CL_CMP   = 3'd6
  } cls_e;

  typedef struct packed {
    logic [MAJ_W-1:0]  major;
    logic [IDX_W-1:0]  d;
    logic [IDX_W-1:0]  a;
    logic [IDX_W-1:0]  b;
    logic              dp;
    logic              ap;
    logic              bp;
    logic [FUNC_W-1:0] func;
  } fields_t;

endpackage

// File: rtl/fpd_fields.sv
module fpd_fields
  import fpd_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output fields_t           fld_o
);

  assign fld_o = fields_t'(insn_i);

endmodule

// File: rtl/fpd_func_table.sv
module fpd_func_table
  import fpd_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output op_e               op_o,
  output cls_e              cls_o,
  output logic              swap_o,
  output logic              inv_o
);

  always_comb begin
    op_o   = OP_NONE;
    cls_o  = CL_NONE;
    swap_o = 1'b0;
    inv_o  = 1'b0;
    unique case (func_i)
      FN_ADD: begin op_o = OP_ADD; cls_o = CL_ARITH; end
      FN_SUB: begin op_o = OP_SUB; cls_o = CL_ARITH; end
      FN_MUL: begin op_o = OP_MUL; cls_o = CL_ARITH; end
      FN_DIV: begin op_o = OP_DIV; cls_o = CL_ARITH; end
      FN_REM: begin op_o = OP_REM; cls_o = CL_ARITH; end
      FN_FMA: begin op_o = OP_FMA; cls_o = CL_FMA;   end
      FN_I2F: begin op_o = OP_I2F; cls_o = CL_CONV;  end
      FN_F2I: begin op_o = OP_F2I; cls_o = CL_CONV;  end
      FN_S2D: begin op_o = OP_S2D; cls_o = CL_S2D;   end
      FN_D2S: begin op_o = OP_D2S; cls_o = CL_D2S;   end
      FN_CEQ: begin op_o = OP_CEQ; cls_o = CL_CMP;   end
      FN_CNE: begin op_o = OP_CEQ; cls_o = CL_CMP; inv_o  = 1'b1; end
      FN_CLT: begin op_o = OP_CLT; cls_o = CL_CMP;   end
      FN_CGT: begin op_o = OP_CLT; cls_o = CL_CMP; swap_o = 1'b1; end
      FN_CLE: begin op_o = OP_CLE; cls_o = CL_CMP;   end
      FN_CGE: begin op_o = OP_CLE; cls_o = CL_CMP; swap_o = 1'b1; end
      default: begin
        op_o  = OP_NONE;
        cls_o = CL_NONE;
      end
    endcase
  end

endmodule

// File: rtl/fpd_pair_index.sv
module fpd_pair_index #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] base_i,
  input  logic             stride_i,
  output logic [IDX_W-1:0] partner_o,
  output logic             fits_o
);

  localparam int SUM_W = IDX_W + 1;

  logic [SUM_W-1:0] sum;

  assign sum       = {1'b0, base_i} + SUM_W'(1) + {{IDX_W{1'b0}}, stride_i};
  assign partner_o = sum[IDX_W-1:0];
  assign fits_o    = ~sum[IDX_W];

endmodule

// File: rtl/fpd_pair_decoder.sv
module fpd_pair_decoder
  import fpd_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic        fp64_en_i,
  output logic [3:0]  op_o,
  output logic [4:0]  src_a_hi_o,
  output logic [4:0]  src_a_lo_o,
  output logic [4:0]  src_b_hi_o,
  output logic [4:0]  src_b_lo_o,
  output logic [4:0]  dst_hi_o,
  output logic [4:0]  dst_lo_o,
  output logic [1:0]  src_a_re_o,
  output logic [1:0]  src_b_re_o,
  output logic [1:0]  acc_re_o,
  output logic [1:0]  dst_we_o,
  output logic        cmp_swap_o,
  output logic        cmp_inv_o,
  output logic        illegal_o
);

  fields_t          fld;
  op_e              tbl_op;
  cls_e             tbl_cls;
  logic             tbl_swap;
  logic             tbl_inv;

  logic [IDX_W-1:0] base    [NPAIR];
  logic             stride  [NPAIR];
  logic [IDX_W-1:0] partner [NPAIR];
  logic [NPAIR-1:0] fits;

  logic [NPAIR-1:0] pair_used;
  logic             rsv_ok;
  logic             legal;
  logic [1:0]       a_re_raw, b_re_raw, acc_raw, d_we_raw;

  fpd_fields u_fields (
    .insn_i (insn_i),
    .fld_o  (fld)
  );

  fpd_func_table u_table (
    .func_i (fld.func),
    .op_o   (tbl_op),
    .cls_o  (tbl_cls),
    .swap_o (tbl_swap),
    .inv_o  (tbl_inv)
  );

  assign base[OPND_A]   = fld.a;
  assign base[OPND_B]   = fld.b;
  assign base[OPND_D]   = fld.d;
  assign stride[OPND_A] = fld.ap;
  assign stride[OPND_B] = fld.bp;
  assign stride[OPND_D] = fld.dp;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    fpd_pair_index #(.IDX_W(IDX_W)) u_idx (
      .base_i    (base[g]),
      .stride_i  (stride[g]),
      .partner_o (partner[g]),
      .fits_o    (fits[g])
    );
  end

  // Per-class operand usage, reserved-field rules and raw enables.
  always_comb begin
    pair_used = '0;
    rsv_ok    = 1'b1;
    a_re_raw  = 2'b00;
    b_re_raw  = 2'b00;
    acc_raw   = 2'b00;
    d_we_raw  = 2'b00;
    unique case (tbl_cls)
      CL_ARITH, CL_FMA: begin
        pair_used[OPND_A] = 1'b1;
        pair_used[OPND_B] = 1'b1;
        pair_used[OPND_D] = 1'b1;
        a_re_raw = 2'b11;
        b_re_raw = 2'b11;
        d_we_raw = 2'b11;
        acc_raw  = (tbl_cls == CL_FMA) ? 2'b11 : 2'b00;
      end
      CL_CONV: begin
        pair_used[OPND_A] = 1'b1;
        pair_used[OPND_D] = 1'b1;
        rsv_ok   = (fld.b == '0) && !fld.bp;
        a_re_raw = 2'b11;
        d_we_raw = 2'b11;
      end
      CL_S2D: begin
        pair_used[OPND_D] = 1'b1;
        rsv_ok   = (fld.b == '0) && !fld.ap && !fld.bp;
        a_re_raw = 2'b10;
        d_we_raw = 2'b11;
      end
      CL_D2S: begin
        pair_used[OPND_A] = 1'b1;
        rsv_ok   = (fld.b == '0) && !fld.dp && !fld.bp;
        a_re_raw = 2'b11;
        d_we_raw = 2'b10;
      end
      CL_CMP: begin
        pair_used[OPND_A] = 1'b1;
        pair_used[OPND_B] = 1'b1;
        rsv_ok   = (fld.d == '0) && !fld.dp;
        a_re_raw = 2'b11;
        b_re_raw = 2'b11;
      end
      default: begin
        rsv_ok = 1'b0;
      end
    endcase
  end

  assign legal = (fld.major == FPD_MAJOR) && fp64_en_i && (tbl_cls != CL_NONE)
               && rsv_ok && ((pair_used & ~fits) == '0);

  assign illegal_o  = ~legal;
  assign op_o       = legal ? tbl_op : OP_NONE;
  assign src_a_re_o = legal ? a_re_raw : 2'b00;
  assign src_b_re_o = legal ? b_re_raw : 2'b00;
  assign acc_re_o   = legal ? acc_raw  : 2'b00;
  assign dst_we_o   = legal ? d_we_raw : 2'b00;
  assign cmp_swap_o = legal & tbl_swap;
  assign cmp_inv_o  = legal & tbl_inv;

  assign src_a_hi_o = base[OPND_A];
  assign src_a_lo_o = partner[OPND_A];
  assign src_b_hi_o = base[OPND_B];
  assign src_b_lo_o = partner[OPND_B];
  assign dst_hi_o   = base[OPND_D];
  assign dst_lo_o   = partner[OPND_D];

endmodule

// File: rtl/fpd_pair_decoder_chk.sv
module fpd_pair_decoder_chk
  import fpd_pkg::*;
(
  input logic       fp64_en_i,
  input logic [3:0] op_o,
  input logic [4:0] src_a_hi_o,
  input logic [4:0] src_a_lo_o,
  input logic [4:0] src_b_hi_o,
  input logic [4:0] src_b_lo_o,
  input logic [4:0] dst_hi_o,
  input logic [4:0] dst_lo_o,
  input logic [1:0] src_a_re_o,
  input logic [1:0] src_b_re_o,
  input logic [1:0] acc_re_o,
  input logic [1:0] dst_we_o,
  input logic       cmp_swap_o,
  input logic       cmp_inv_o,
  input logic       illegal_o
);

  always_comb begin
    // R13
    quiet_when_illegal_chk: assert (!illegal_o ||
      (op_o == OP_NONE && src_a_re_o == 2'b00 && src_b_re_o == 2'b00 &&
       acc_re_o == 2'b00 && dst_we_o == 2'b00 && !cmp_swap_o && !cmp_inv_o))
      else $error("enables active on illegal instruction");
    // R2
    feature_gate_chk: assert (fp64_en_i || illegal_o)
      else $error("decode accepted with feature disabled");
    // R7
    cmp_ctrl_scope_chk: assert (!(cmp_swap_o || cmp_inv_o) ||
      (op_o == OP_CEQ || op_o == OP_CLT || op_o == OP_CLE))
      else $error("compare control outside compare");
    // R7
    swap_inv_excl_chk: assert (!(cmp_swap_o && cmp_inv_o))
      else $error("swap and invert together");
    // R12
    acc_only_fma_chk: assert (acc_re_o == 2'b00 || op_o == OP_FMA)
      else $error("accumulator read outside fused multiply-add");
    // R6
    a_pair_order_chk: assert (src_a_re_o != 2'b11 || src_a_lo_o > src_a_hi_o)
      else $error("operand a partner wrapped");
    // R6
    b_pair_order_chk: assert (src_b_re_o != 2'b11 || src_b_lo_o > src_b_hi_o)
      else $error("operand b partner wrapped");
    // R6
    d_pair_order_chk: assert (dst_we_o != 2'b11 || dst_lo_o > dst_hi_o)
      else $error("destination partner wrapped");
  end

endmodule

bind fpd_pair_decoder fpd_pair_decoder_chk u_chk (
  .fp64_en_i  (fp64_en_i),
  .op_o       (op_o),
  .src_a_hi_o (src_a_hi_o),
  .src_a_lo_o (src_a_lo_o),
  .src_b_hi_o (src_b_hi_o),
  .src_b_lo_o (src_b_lo_o),
  .dst_hi_o   (dst_hi_o),
  .dst_lo_o   (dst_lo_o),
  .src_a_re_o (src_a_re_o),
  .src_b_re_o (src_b_re_o),
  .acc_re_o   (acc_re_o),
  .dst_we_o   (dst_we_o),
  .cmp_swap_o (cmp_swap_o),
  .cmp_inv_o  (cmp_inv_o),
  .illegal_o  (illegal_o)
);

// File: tb/fpd_pair_decoder_test.sv
module fpd_pair_decoder_test;

  logic        clk;
  logic        rst_n;
  logic [31:0] insn;
  logic        en;

  logic [3:0] op;
  logic [4:0] ahi, alo, bhi, blo, dhi, dlo;
  logic [1:0] are, bre, acc, dwe;
  logic       swp, inv, ill;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  fpd_pair_decoder uut (
    .insn_i     (insn),
    .fp64_en_i  (en),
    .op_o       (op),
    .src_a_hi_o (ahi),
    .src_a_lo_o (alo),
    .src_b_hi_o (bhi),
    .src_b_lo_o (blo),
    .dst_hi_o   (dhi),
    .dst_lo_o   (dlo),
    .src_a_re_o (are),
    .src_b_re_o (bre),
    .acc_re_o   (acc),
    .dst_we_o   (dwe),
    .cmp_swap_o (swp),
    .cmp_inv_o  (inv),
    .illegal_o  (ill)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Expected bundle: {op, ahi, alo, bhi, blo, dhi, dlo, are, bre, acc, dwe, swp, inv, ill}
  function automatic logic [44:0] model(input logic [31:0] w, input logic e);
    int d, a, b, pa, pb, pd;
    logic dp, ap, bp;
    logic [7:0] f;
    logic [3:0] xop;
    logic [1:0] xa, xb, xc, xd;
    logic xs, xi, known, rsv, ua, ub, ud, lg;
    d  = int'(w[25:21]); a = int'(w[20:16]); b = int'(w[15:11]);
    dp = w[10]; ap = w[9]; bp = w[8]; f = w[7:0];
    pa = a + 1 + int'(ap); pb = b + 1 + int'(bp); pd = d + 1 + int'(dp);
    xop = 0; xa = 0; xb = 0; xc = 0; xd = 0; xs = 0; xi = 0;
    known = 1; rsv = 1; ua = 0; ub = 0; ud = 0;
    case (f)
      8'h10, 8'h11, 8'h12, 8'h13, 8'h16, 8'h17: begin
        case (f)
          8'h10: xop = 1; 8'h11: xop = 2; 8'h12: xop = 3;
          8'h13: xop = 4; 8'h16: xop = 5; default: xop = 6;
        endcase
        ua = 1; ub = 1; ud = 1; xa = 2'b11; xb = 2'b11; xd = 2'b11;
        if (f == 8'h17) xc = 2'b11;
      end
      8'h14, 8'h15: begin
        xop = (f == 8'h14) ? 4'd7 : 4'd8;
        ua = 1; ud = 1; xa = 2'b11; xd = 2'b11;
        rsv = (b == 0) && !bp;
      end
      8'h34: begin
        xop = 9; ud = 1; xa = 2'b10; xd = 2'b11;
        rsv = (b == 0) && !ap && !bp;
      end
      8'h35: begin
        xop = 10; ua = 1; xa = 2'b11; xd = 2'b10;
        rsv = (b == 0) && !dp && !bp;
      end
      8'h18, 8'h19, 8'h1A, 8'h1B, 8'h1C, 8'h1D: begin
        case (f)
          8'h18, 8'h19: xop = 11;
          8'h1A, 8'h1C: xop = 12;
          default:      xop = 13;
        endcase
        xs = (f == 8'h1A) || (f == 8'h1B);
        xi = (f == 8'h19);
        ua = 1; ub = 1; xa = 2'b11; xb = 2'b11;
        rsv = (d == 0) && !dp;
      end
      default: known = 0;
    endcase
    lg = (w[31:26] == 6'b110010) && e && known && rsv &&
         !(ua && pa >= 32) && !(ub && pb >= 32) && !(ud && pd >= 32);
    if (!lg) begin
      xop = 0; xa = 0; xb = 0; xc = 0; xd = 0; xs = 0; xi = 0;
    end
    return {xop, 5'(a), 5'(pa % 32), 5'(b), 5'(pb % 32), 5'(d), 5'(pd % 32),
            xa, xb, xc, xd, xs, xi, !lg};
  endfunction

  function automatic logic [31:0] mk(input int maj, input int d, input int a,
                                     input int b, input int dp, input int ap,
                                     input int bp, input int f);
    return {6'(maj), 5'(d), 5'(a), 5'(b), 1'(dp), 1'(ap), 1'(bp), 8'(f)};
  endfunction

  task automatic apply(input logic [31:0] w, input logic e, input string tag);
    logic [44:0] got, exp;
    @(posedge clk);
    insn = w;
    en   = e;
    @(negedge clk);
    got = {op, ahi, alo, bhi, blo, dhi, dlo, are, bre, acc, dwe, swp, inv, ill};
    exp = model(w, e);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s insn=%h en=%0b actual=%h expected=%h", tag, w, e, got, exp);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int fs [7][6];
    fs = '{'{0, 0, 0, 0, 0, 0}, '{2, 4, 6, 1, 0, 1}, '{0, 5, 0, 0, 1, 0},
           '{31, 3, 0, 0, 0, 0}, '{0, 30, 31, 0, 1, 1}, '{3, 7, 9, 0, 0, 0},
           '{0, 29, 0, 1, 1, 1}};
    rst_n = 1'b0;
    insn  = '0;
    en    = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // R1 R2: initial idle word must decode as illegal
    apply(32'h0, 1'b0, "R1 R2 initial");

    // R1: every major opcode with a valid function code
    for (int m = 0; m < 64; m++)
      apply(mk(m, 2, 4, 6, 0, 0, 0, 'h10), 1'b1, "R1 major sweep");

    // R3 R4 R7 R8 R9 R10 R11 R12 R13: all function codes, several field patterns
    for (int f = 0; f < 256; f++)
      for (int k = 0; k < 7; k++) begin
        apply(mk(6'b110010, fs[k][0], fs[k][1], fs[k][2], fs[k][3], fs[k][4], fs[k][5], f),
              1'b1, "R3 R4 R7 R8 R9 R10 R11 R12 R13 func sweep");
        // R2: same word with the feature disabled
        apply(mk(6'b110010, fs[k][0], fs[k][1], fs[k][2], fs[k][3], fs[k][4], fs[k][5], f),
              1'b0, "R2 disabled sweep");
      end

    // R5 R6: every base and stride on each operand position
    for (int r = 0; r < 32; r++)
      for (int p = 0; p < 2; p++) begin
        apply(mk(6'b110010, 0, r, 0, 0, p, 0, 'h10), 1'b1, "R5 R6 a bound add");
        apply(mk(6'b110010, 0, 0, r, 0, 0, p, 'h18), 1'b1, "R5 R6 b bound cmp");
        apply(mk(6'b110010, r, 0, 0, p, 0, 0, 'h34), 1'b1, "R5 R6 R10 d bound s2d");
        apply(mk(6'b110010, r, r, 0, 0, p, 0, 'h35), 1'b1, "R5 R6 R11 a bound d2s");
        apply(mk(6'b110010, r, 0, 0, p, 0, 0, 'h17), 1'b1, "R5 R6 R12 d bound fma");
        apply(mk(6'b110010, 0, r, r, 0, 0, p, 'h14), 1'b1, "R5 R6 R9 b unused conv");
      end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule